// File: doc/BRIEF.md
# Debug Control and Break Register

This block is the 8-bit control register of an on-chip debugger for a small 8-bit microcontroller. Software and the debug host reach it through a plain write port and a read port. It holds three control bits: a debug-mode flag that stops instruction fetch, an enable for break instructions, and an enable for the acknowledge message sent to the host. A fourth bit asks for a reset of the whole device, and the debugger itself stays out of that reset.

The CPU core sends a strobe when it decodes a break instruction. If breakpoints are enabled, the block sets the debug-mode flag and holds the halt-fetch output high. If the acknowledge enable is also set and the device was not already halted, the block raises a one-cycle request to send an acknowledge character to the host.

A read-protect option input can be active. While it is, software cannot clear the debug-mode flag, and only a reset of the block clears it. The reset-request bit stays set until the reset sequencer reports that the reset has ended.

Top module: `dbg_ctl_reg`

## Requirements
- R1: After a synchronous active-low reset, the register reads 00H and halt_fetch, sys_rst_req and ack_send are all 0.
- R2: halt_fetch equals register bit 7 (debug mode). With rd_protect low, a write sets bit 7 to the value of wr_data[7].
- R3: When bit 6 is 1 and brk_decoded is high, bit 7 reads 1 from the next cycle. This holds even if a write in the same cycle carries 0 in bit 7, because the hardware set wins.
- R4: When bit 6 is 0, brk_decoded changes neither the register nor ack_send.
- R5: While rd_protect is high, a write with wr_data[7]=0 leaves bit 7 at 1. A write with wr_data[7]=1 still sets it, and the block reset still clears it.
- R6: ack_send is high for exactly the one cycle after a break is accepted, and only when bit 5 was 1 and bit 7 was 0 in the cycle of the break.
- R7: Bits 4 to 1 always read 0, whatever value is written to them.
- R8: A write with wr_data[0]=1 sets bit 0 and sys_rst_req from the next cycle. Both stay 1 until the cycle after reset_done is high. Writing 0 to bit 0 has no effect.
- R9: A write stores wr_data[6] in bit 6 (breakpoint enable) and wr_data[5] in bit 5 (acknowledge enable). These bits read back that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the debugger |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register contents |
| brk_decoded | input | 1 | One-cycle strobe: the CPU decoded a break instruction |
| rd_protect | input | 1 | Read-protect option level |
| reset_done | input | 1 | The device reset sequence has ended |
| halt_fetch | output | 1 | Stop fetching new instructions |
| sys_rst_req | output | 1 | Request a device reset |
| ack_send | output | 1 | One-cycle request to send the acknowledge character |

## Verification
The bench sweeps every prior combination of the three control bits against the read-protect level, the break strobe, the write strobe and several write patterns. This covers the case where a break and a clearing write land in the same cycle. A design that let software win that race would drop a breakpoint. A design that ignored protection would let a clearing write release a halted, protected device. The sweep also covers breaks that arrive while the device is already halted, where a wrong design would send a duplicate acknowledge. The reset-request bit is checked for holding through unrelated writes and for clearing only after the end-of-reset indication.

// File: rtl/dbg_ctl_pkg.sv
// Shared sizes and bit positions of the debug control register.
// Assumes one 8-bit register; the bit positions are decoded by software.
package dbg_ctl_pkg;
    localparam int REG_W     = 8;
    localparam int BIT_MODE  = 7;
    localparam int BIT_BRKEN = 6;
    localparam int BIT_ACKEN = 5;
    localparam int BIT_RST   = 0;
    localparam int RSV_LO    = 1;
    localparam int RSV_HI    = 4;
endpackage

// File: rtl/dbg_mode_flag.sv
// Debug-mode flag: the hardware set on an accepted break has priority over a
// software write; a software clear is blocked while read protection is on.
// Assumes a synchronous active-low reset that always clears the flag.
module dbg_mode_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_hit,
    input  logic sw_wr,
    input  logic sw_val,
    input  logic protect,
    output logic mode
);
    logic mode_d;

    // Next-state selection: hardware set, then software write, then hold.
    always_comb begin
        mode_d = mode;
        if (brk_hit)
            mode_d = 1'b1;
        else if (sw_wr && sw_val)
            mode_d = 1'b1;
        else if (sw_wr && !protect)
            mode_d = 1'b0;
    end

    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= 1'b0;
        else        mode <= mode_d;
    end

    // R3: an accepted break always leaves the flag set.
    a_r3_brk_sets_mode: assert property (@(posedge clk) disable iff (!rst_n)
        brk_hit |=> mode);
    // R5: a protected, halted device stays halted.
    a_r5_protect_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && protect) |=> mode);
    // R4: without a break or write the flag does not move.
    a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!brk_hit && !sw_wr) |=> $stable(mode));
endmodule

// File: rtl/dbg_ack_pulse.sv
// Acknowledge request: a one-cycle pulse in the cycle the debug-mode flag
// rises because of a break, when the acknowledge enable is set.
// Assumes brk_hit already includes the breakpoint enable.
module dbg_ack_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_hit,
    input  logic mode,
    input  logic ack_en,
    output logic ack
);
    // Register the pulse so it lines up with the flag's rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) ack <= 1'b0;
        else        ack <= brk_hit && !mode && ack_en;
    end

    // R6: the pulse lasts exactly one cycle.
    a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    // R6: a pulse only ever accompanies a set debug-mode flag.
    a_r6_with_mode: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> mode);
endmodule

// File: rtl/dbg_rst_req.sv
// Reset-request bit: set by a write of 1, held until end of reset is seen.
// Assumes a new request written in the cycle of reset_done wins.
module dbg_rst_req (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic reset_done,
    output logic req
);
    // Request register with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          req <= 1'b0;
        else if (set_req)    req <= 1'b1;
        else if (reset_done) req <= 1'b0;
    end

    // R8: the request holds until the end of reset.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !reset_done) |=> req);
    // R8: it never rises without a write.
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !set_req) |=> !req);
endmodule

// File: rtl/dbg_ctl_reg.sv
// Top of the debug control register: holds the enable bits and joins the
// mode flag, acknowledge pulse and reset request. Reserved bits read 0.
// Assumes wr_en and brk_decoded are single-cycle strobes synchronous to clk.
module dbg_ctl_reg
    import dbg_ctl_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    input  logic         brk_decoded,
    input  logic         rd_protect,
    input  logic         reset_done,
    output logic         halt_fetch,
    output logic         sys_rst_req,
    output logic         ack_send
);
    logic brk_en_q, ack_en_q, mode_q, rst_q, brk_hit;
    logic unused_rsv;

    assign brk_hit    = brk_decoded && brk_en_q;
    assign unused_rsv = ^wr_data[RSV_HI:RSV_LO];

    // Enable bits, written directly by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_en_q <= 1'b0;
            ack_en_q <= 1'b0;
        end else if (wr_en) begin
            brk_en_q <= wr_data[BIT_BRKEN];
            ack_en_q <= wr_data[BIT_ACKEN];
        end
    end

    dbg_mode_flag u_mode (
        .clk(clk), .rst_n(rst_n), .brk_hit(brk_hit), .sw_wr(wr_en),
        .sw_val(wr_data[BIT_MODE]), .protect(rd_protect), .mode(mode_q)
    );

    dbg_ack_pulse u_ack (
        .clk(clk), .rst_n(rst_n), .brk_hit(brk_hit), .mode(mode_q),
        .ack_en(ack_en_q), .ack(ack_send)
    );

    dbg_rst_req u_rst (
        .clk(clk), .rst_n(rst_n), .set_req(wr_en && wr_data[BIT_RST]),
        .reset_done(reset_done), .req(rst_q)
    );

    // Read view assembled from the stored bits; reserved bits stay 0.
    always_comb begin
        rd_data            = '0;
        rd_data[BIT_MODE]  = mode_q;
        rd_data[BIT_BRKEN] = brk_en_q;
        rd_data[BIT_ACKEN] = ack_en_q;
        rd_data[BIT_RST]   = rst_q;
    end

    assign halt_fetch  = mode_q;
    assign sys_rst_req = rst_q;

    // R7: reserved field never reads nonzero.
    a_r7_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[RSV_HI:RSV_LO] == '0);
    // R4: a break with breakpoints off raises no acknowledge.
    a_r4_no_ack_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_decoded && !brk_en_q) |=> !ack_send);
endmodule

// File: tb/tb_dbg_ctl_reg.sv
`timescale 1ns/1ps
module tb_dbg_ctl_reg;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic brk_decoded = 1'b0, rd_protect = 1'b0, reset_done = 1'b0;
    logic halt_fetch, sys_rst_req, ack_send;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbg_ctl_reg dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .brk_decoded(brk_decoded), .rd_protect(rd_protect),
        .reset_done(reset_done), .halt_fetch(halt_fetch),
        .sys_rst_req(sys_rst_req), .ack_send(ack_send)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge, sample just after the rising edge.
    task automatic cyc(input logic r, input logic w, input logic [7:0] d,
                       input logic b, input logic p, input logic rd);
        @(negedge clk);
        rst_n = r; wr_en = w; wr_data = d; brk_decoded = b;
        rd_protect = p; reset_done = rd;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        cyc(1'b1, 1'b0, 8'h00, 1'b0, rd_protect, 1'b0);
    endtask

    logic [7:0] pats [4] = '{8'h00, 8'hFE, 8'h1E, 8'hA0};

    initial begin
        cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        chk("R1 reg", rd_data, 8'h00);
        chk("R1 outs", {5'b0, halt_fetch, sys_rst_req, ack_send}, 8'h00);

        // Near-exhaustive sweep: prior state x protect x break x write x pattern.
        for (int st = 0; st < 8; st++)
            for (int p = 0; p < 2; p++)
                for (int b = 0; b < 2; b++)
                    for (int w = 0; w < 2; w++)
                        for (int k = 0; k < 4; k++) begin
                            logic m0, e0, a0, m1, e1, a1, ak;
                            logic [7:0] wd;
                            m0 = st[2]; e0 = st[1]; a0 = st[0]; wd = pats[k];
                            cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
                            chk("R1 reset clears", rd_data, 8'h00);
                            cyc(1'b1, 1'b1, {m0, e0, a0, 5'b0}, 1'b0, 1'b0, 1'b0);
                            chk("R2 R9 setup", rd_data, {m0, e0, a0, 5'b0});
                            cyc(1'b1, w[0], wd, b[0], p[0], 1'b0);
                            ak = b[0] && e0 && !m0 && a0;
                            if (b[0] && e0)       m1 = 1'b1;
                            else if (w[0] && wd[7]) m1 = 1'b1;
                            else if (w[0] && !p[0]) m1 = 1'b0;
                            else                   m1 = m0;
                            e1 = w[0] ? wd[6] : e0;
                            a1 = w[0] ? wd[5] : a0;
                            chk("R3 R4 R5 R7 R9 reg", rd_data, {m1, e1, a1, 5'b0});
                            chk("R2 halt", {7'b0, halt_fetch}, {7'b0, m1});
                            chk("R6 ack", {7'b0, ack_send}, {7'b0, ak});
                            idle();
                            chk("R6 ack one cycle", {7'b0, ack_send}, 8'h00);
                        end

        // Reset request sequence.
        cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        idle();
        cyc(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        chk("R8 idle done", {7'b0, sys_rst_req}, 8'h00);
        cyc(1'b1, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0);
        chk("R8 set", {7'b0, sys_rst_req}, 8'h01);
        chk("R8 readback", rd_data, 8'h01);
        cyc(1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
        chk("R8 write 0 ignored", {7'b0, sys_rst_req}, 8'h01);
        for (int i = 0; i < 5; i++) idle();
        chk("R8 held", rd_data, 8'h01);
        cyc(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        chk("R8 cleared", {7'b0, sys_rst_req}, 8'h00);
        chk("R8 bit clear", rd_data, 8'h00);

        // Protected halt persists until block reset.
        cyc(1'b1, 1'b1, 8'h80, 1'b0, 1'b1, 1'b0);
        cyc(1'b1, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0);
        chk("R5 protected clear", {7'b0, halt_fetch}, 8'h01);
        cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        chk("R5 reset clears", rd_data, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule